// File: doc/BRIEF.md
# Serial Bit-Reversal Sequencer

This block mirrors the bit order of a word without a crossbar of wires. It walks through the word one bit at a time under a small control state machine. A one-cycle start pulse hands it a source word. The sequencer first zeroes its result register. It then takes a working copy of the source and arms an iteration counter with the word width. In each loop pass the result register moves one place towards the most significant end. When the lowest bit of the working copy is set, a separate step then sets the result's lowest bit. After that the working copy moves one place towards the least significant end and the counter steps down by one. When the counter runs out, the sequencer leaves the loop and raises a one-cycle done pulse.

The run time depends on the data: every set bit in the source costs one extra cycle. A busy flag covers the whole run, and any start that arrives during it is dropped. The result stays unchanged from the done pulse until a new operation clears it. This makes the block suited to controllers that can hold off for a data-dependent number of cycles and want to spend little area.

Top module: `bitrev_seq`

## Requirements
- R1: While reset is asserted and directly after it, `busy_o` and `done_o` are 0 and `result_o` is 0.
- R2: A `start_i` sampled high at a clock edge while `busy_o` is low is accepted, and `busy_o` is 1 in the cycle that follows that edge.
- R3: `busy_o` stays 1 without a gap from the cycle after acceptance up to and including the cycle in which `done_o` is 1. In the cycle after `done_o`, `busy_o` is 0.
- R4: `done_o` is high for exactly one cycle per accepted operation.
- R5: When `done_o` is 1, bit k of `result_o` equals bit DATA_W-1-k of the source word sampled at acceptance, for every k.
- R6: Take the accepting edge as edge 0 and let P be the number of 1 bits in the source. Then `done_o` is 1 in the cycle after edge 3+3*DATA_W+P. With DATA_W=16 this is edge 51+P.
- R7: A `start_i` that is high while `busy_o` is 1, including the done cycle, is ignored. It changes neither the timing nor the result of the operation in progress.
- R8: While `busy_o` is 0, `result_o` does not change.
- R9: `src_i` is sampled only at the accepting edge. Changes to it during a run have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, one cycle |
| src_i | input | DATA_W | Source word, sampled on acceptance |
| busy_o | output | 1 | High while an operation runs |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | DATA_W | Bit-reversed word |

## Verification
The bench covers the extremes of the data-dependent latency. An all-zero word never takes the conditional set step, and an all-ones word takes it on every pass. A design that skipped the extra cycle or ran the wrong number of passes would move the done pulse or the busy edge. Single-bit words at either end would show a pass missing at the start or the end of the loop, because the set bit would land in the wrong position. Start pulses that arrive in the middle of a run and in the done cycle itself would restart or corrupt a sequencer that did not gate its start. A source word that keeps changing during a run would show up as a wrong result in a design that read the port after the accepting edge.

// File: rtl/bitrev_pkg.sv
package bitrev_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_CLEAR,
      ST_COPY,
      ST_ARM,
      ST_SHL,
      ST_SETB,
      ST_SHR,
      ST_DECR,
      ST_FIN
   } seq_state_e;

   typedef struct packed {
      logic clr;
      logic copy;
      logic arm;
      logic shl;
      logic setb;
      logic shr;
      logic decr;
   } seq_ctl_t;

endpackage

// File: rtl/bitrev_ctrl.sv
module bitrev_ctrl
   import bitrev_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     start_i,
   input  logic     lsb_i,
   input  logic     cnt_last_i,
   output seq_ctl_t ctl_o,
   output logic     accept_o,
   output logic     busy_o,
   output logic     done_o
);

   seq_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      case (state_q)
         ST_IDLE:  if (start_i) state_d = ST_CLEAR;
         ST_CLEAR: state_d = ST_COPY;
         ST_COPY:  state_d = ST_ARM;
         ST_ARM:   state_d = ST_SHL;
         ST_SHL:   state_d = lsb_i ? ST_SETB : ST_SHR;
         ST_SETB:  state_d = ST_SHR;
         ST_SHR:   state_d = ST_DECR;
         ST_DECR:  state_d = cnt_last_i ? ST_FIN : ST_SHL;
         ST_FIN:   state_d = ST_IDLE;
         default:  state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

   always_comb begin
      ctl_o      = '0;
      ctl_o.clr  = (state_q == ST_CLEAR);
      ctl_o.copy = (state_q == ST_COPY);
      ctl_o.arm  = (state_q == ST_ARM);
      ctl_o.shl  = (state_q == ST_SHL);
      ctl_o.setb = (state_q == ST_SETB);
      ctl_o.shr  = (state_q == ST_SHR);
      ctl_o.decr = (state_q == ST_DECR);
   end

   assign accept_o = (state_q == ST_IDLE) && start_i;
   assign busy_o   = (state_q != ST_IDLE);
   assign done_o   = (state_q == ST_FIN);

   p_done_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   p_busy_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !done_o) |=> busy_o);
   p_idle_after_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !busy_o);
   p_accept_rises_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
      accept_o |=> busy_o);
   p_set_needs_lsb_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_o.setb |-> lsb_i);

endmodule

// File: rtl/bitrev_src_shifter.sv
module bitrev_src_shifter #(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic              shr_i,
   input  logic [DATA_W-1:0] load_val_i,
   output logic              lsb_o
);

   logic [DATA_W-1:0] work_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      work_q <= '0;
      else if (load_i) work_q <= load_val_i;
      else if (shr_i)  work_q <= {1'b0, work_q[DATA_W-1:1]};
   end

   assign lsb_o = work_q[0];

   p_load_copies_r9: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (work_q == $past(load_val_i)));
   p_shr_zero_fill_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (shr_i && !load_i) |=> !work_q[DATA_W-1]);

endmodule

// File: rtl/bitrev_loop_counter.sv
module bitrev_loop_counter #(
   parameter int DATA_W = 16,
   localparam int CNT_W = $clog2(DATA_W + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm_i,
   input  logic decr_i,
   output logic last_o
);

   localparam logic [CNT_W-1:0] ARM_VAL = CNT_W'(DATA_W);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (arm_i)  cnt_q <= ARM_VAL;
      else if (decr_i) cnt_q <= cnt_q - 1'b1;
   end

   assign last_o = (cnt_q == CNT_W'(1));

   p_no_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      decr_i |-> (cnt_q != '0));
   p_arm_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
      arm_i |=> (cnt_q == ARM_VAL));

endmodule

// File: rtl/bitrev_accum.sv
module bitrev_accum #(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_i,
   input  logic              shl_i,
   input  logic              setb_i,
   output logic [DATA_W-1:0] acc_o
);

   logic [DATA_W-1:0] acc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      acc_q <= '0;
      else if (clr_i)  acc_q <= '0;
      else if (shl_i)  acc_q <= {acc_q[DATA_W-2:0], 1'b0};
      else if (setb_i) acc_q <= acc_q | DATA_W'(1);
   end

   assign acc_o = acc_q;

   p_setb_on_free_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
      setb_i |-> !acc_q[0]);
   p_clear_zeroes_r5: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (acc_q == '0));

endmodule

// File: rtl/bitrev_seq.sv
module bitrev_seq
   import bitrev_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [DATA_W-1:0] src_i,
   output logic              busy_o,
   output logic              done_o,
   output logic [DATA_W-1:0] result_o
);

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("bitrev_seq: DATA_W must be at least 2");
      end
   endgenerate

   seq_ctl_t          ctl;
   logic              accept;
   logic              lsb;
   logic              cnt_last;
   logic [DATA_W-1:0] hold_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      hold_q <= '0;
      else if (accept) hold_q <= src_i;
   end

   bitrev_ctrl u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .lsb_i      (lsb),
      .cnt_last_i (cnt_last),
      .ctl_o      (ctl),
      .accept_o   (accept),
      .busy_o     (busy_o),
      .done_o     (done_o)
   );

   bitrev_src_shifter #(.DATA_W(DATA_W)) u_shift (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (ctl.copy),
      .shr_i      (ctl.shr),
      .load_val_i (hold_q),
      .lsb_o      (lsb)
   );

   bitrev_loop_counter #(.DATA_W(DATA_W)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .arm_i  (ctl.arm),
      .decr_i (ctl.decr),
      .last_o (cnt_last)
   );

   bitrev_accum #(.DATA_W(DATA_W)) u_acc (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (ctl.clr),
      .shl_i  (ctl.shl),
      .setb_i (ctl.setb),
      .acc_o  (result_o)
   );

   logic [DATA_W-1:0] mirror;
   always_comb begin
      for (int k = 0; k < DATA_W; k++) mirror[k] = hold_q[DATA_W-1-k];
   end

   p_result_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |=> $stable(result_o));
   p_result_mirror_r5: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (result_o == mirror));
   p_hold_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |=> $stable(hold_q));

endmodule

// File: tb/test_bitrev_seq.sv
module test_bitrev_seq;
   localparam int W = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start_i = 1'b0;
   logic [W-1:0] src_i = '0;
   logic         busy_o, done_o;
   logic [W-1:0] result_o;

   int n_vec = 0;
   int n_bad = 0;
   int cyc = 0;
   string tag = "R1";

   int           m_rem = 0;
   logic [W-1:0] m_res = '0;

   always #10 clk = ~clk;

   bitrev_seq #(.DATA_W(W)) i_bitrev_seq (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .src_i(src_i),
      .busy_o(busy_o), .done_o(done_o), .result_o(result_o)
   );

   function automatic logic [W-1:0] rev(input logic [W-1:0] v);
      logic [W-1:0] r;
      for (int k = 0; k < W; k++) r[k] = v[W-1-k];
      return r;
   endfunction

   function automatic int ones(input logic [W-1:0] v);
      int c = 0;
      for (int k = 0; k < W; k++) c += int'(v[k]);
      return c;
   endfunction

   // behavioural model: remaining busy cycles and expected result
   always @(posedge clk) begin
      if (!rst_n) begin
         m_rem = 0;
         m_res = '0;
      end else if (m_rem > 0) begin
         m_rem = m_rem - 1;
      end else if (start_i) begin
         m_rem = 4 + 3*W + ones(src_i);
         m_res = rev(src_i);
      end
   end

   // per-cycle comparison away from the active edge
   always @(negedge clk) begin
      cyc++;
      if (rst_n) begin
         n_vec++;
         if (busy_o !== (m_rem > 0)) begin
            n_bad++;
            $display("FAIL %s/R3 busy act=%b exp=%b cyc=%0d", tag, busy_o, (m_rem > 0), cyc);
         end
         n_vec++;
         if (done_o !== (m_rem == 1)) begin
            n_bad++;
            $display("FAIL %s/R6 done act=%b exp=%b cyc=%0d", tag, done_o, (m_rem == 1), cyc);
         end
         if (m_rem <= 1) begin
            n_vec++;
            if (result_o !== m_res) begin
               n_bad++;
               $display("FAIL %s/R5 result act=%h exp=%h cyc=%0d", tag, result_o, m_res, cyc);
            end
         end
      end
      if (cyc > 100000) begin
         n_bad++;
         $display("FAIL watchdog act=%0d cycles exp=finished", cyc);
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic wait_idle();
      @(negedge clk);
      while (m_rem != 0) @(negedge clk);
   endtask

   task automatic run_op(input logic [W-1:0] v, input string t);
      int start_cyc, done_cyc;
      tag = t;
      wait_idle();
      start_i = 1'b1;
      src_i   = v;
      @(negedge clk);
      start_cyc = cyc;
      start_i = 1'b0;
      check("R2 busy after start", W'(busy_o), W'(1));
      while (!done_o) @(negedge clk);
      done_cyc = cyc;
      check("R6 latency", W'(done_cyc - start_cyc), W'(3 + 3*W + ones(v)));
      check("R5 reversed", result_o, rev(v));
      @(negedge clk);
      check("R4 done single", W'(done_o), W'(0));
   endtask

   initial begin
      logic [W-1:0] lfsr;
      repeat (3) @(negedge clk);
      check("R1 busy reset", W'(busy_o), W'(0));
      check("R1 done reset", W'(done_o), W'(0));
      check("R1 result reset", result_o, '0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 result after reset", result_o, '0);

      run_op(16'h0000, "R6");
      run_op(16'hFFFF, "R6");
      run_op(16'h0001, "R5");
      run_op(16'h8000, "R5");
      run_op(16'hA5C3, "R5");
      run_op(16'h1234, "R5");
      lfsr = 16'hACE1;
      for (int i = 0; i < 6; i++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         run_op(lfsr, "R5");
      end

      // R7: start during a run and in the done cycle is ignored
      tag = "R7";
      wait_idle();
      start_i = 1'b1; src_i = 16'h00F1;
      @(negedge clk);
      start_i = 1'b0;
      repeat (10) @(negedge clk);
      start_i = 1'b1; src_i = 16'h7777;
      @(negedge clk);
      start_i = 1'b0;
      while (!done_o) @(negedge clk);
      start_i = 1'b1; src_i = 16'h3C00;
      check("R7 result ignores mid start", result_o, rev(16'h00F1));
      @(negedge clk);
      start_i = 1'b0;
      check("R7 done-cycle start ignored", W'(busy_o), W'(0));

      // R8: result held while idle
      tag = "R8";
      src_i = 16'h5555;
      repeat (8) @(negedge clk);
      check("R8 result held idle", result_o, rev(16'h00F1));

      // R9: source changing during the run has no effect
      tag = "R9";
      wait_idle();
      start_i = 1'b1; src_i = 16'hC0DE;
      @(negedge clk);
      start_i = 1'b0;
      while (!done_o) begin
         src_i = src_i ^ 16'h9E37;
         @(negedge clk);
      end
      check("R9 result uses sampled src", result_o, rev(16'hC0DE));

      // R2/R3: start held high, back-to-back acceptance after idle
      tag = "R2";
      wait_idle();
      start_i = 1'b1; src_i = 16'h0F0F;
      repeat (2) begin
         @(negedge clk);
         while (busy_o) @(negedge clk);
         check("R3 idle cycle after done", W'(busy_o), W'(0));
         src_i = 16'h00FF;
      end
      start_i = 1'b0;
      wait_idle();
      repeat (3) @(negedge clk);

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule